// File: doc/BRIEF.md
# Three-Buffer Token Rotation Controller

This block lets three agents share three packet buffers without ever waiting on one another. A writer fills a buffer with one packet, a processor inspects it and decides to keep or drop it, and a forwarder sends kept packets onward. Ownership of each buffer is carried by a 2-bit token (buffer 0, 1 or 2). Each agent has a three-entry token queue, and the token at the head of that queue chooses which buffer the agent is connected to. Completion events move the head token from one queue to the tail of another, so the three agents can work on three different buffers in the same cycle.

The buffers are simple dual-port RAMs held inside the block. Each buffer also records the packet length given when the writer finishes, and that length is shown to the processor and forwarder so they know where the packet ends. An agent whose queue is empty sees its ready output low; its writes and events are then ignored.

Top module: `tribuf_rotator`

## Requirements
- R1: After reset the writer queue holds buffers 0, 1, 2 in that order; `wr_ready` is 1 with `wr_buf` = 0, and `pr_ready` and `fw_ready` are 0.
- R2: A `wr_done` pulse while `wr_ready` is 1 moves the writer's head buffer to the tail of the processor queue; on the next cycle `wr_buf` shows the following buffer in the writer queue.
- R3: A `pr_accept` pulse while `pr_ready` is 1 moves the processor's head buffer to the tail of the forwarder queue.
- R4: A `pr_reject` pulse (with `pr_accept` low) while `pr_ready` is 1 moves the processor's head buffer to the tail of the writer queue.
- R5: A `fw_done` pulse while `fw_ready` is 1 moves the forwarder's head buffer to the tail of the writer queue.
- R6: An agent's ready output is 1 exactly when its queue holds a token; while it is 0, that agent's writes, done, accept and reject inputs have no effect.
- R7: When a reject and a forwarder done both return a buffer to the writer queue in one cycle, the rejected buffer is placed ahead of the forwarded one.
- R8: When `pr_accept` and `pr_reject` are both high, the accept is taken and the reject ignored.
- R9: A word written by the writer at an address is returned on `pr_data` / `fw_data` one cycle after that address is presented by the agent now owning the buffer; `pr_len` / `fw_len` show the `wr_len` captured with the buffer's last `wr_done`.
- R10: The three tokens are conserved: queue occupancies always sum to three and no two ready agents are connected to the same buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_ready | output | 1 | Writer queue holds a buffer |
| wr_buf | output | 2 | Buffer connected to the writer |
| wr_en | input | 1 | Write one word |
| wr_addr | input | ADDR_W | Word address for writes |
| wr_data | input | DATA_W | Word to write |
| wr_done | input | 1 | Writer finished the packet |
| wr_len | input | LEN_W | Packet length captured with `wr_done` |
| pr_ready | output | 1 | Processor queue holds a buffer |
| pr_buf | output | 2 | Buffer connected to the processor |
| pr_addr | input | ADDR_W | Processor read address |
| pr_data | output | DATA_W | Read word, one cycle after address |
| pr_len | output | LEN_W | Length of processor's packet |
| pr_accept | input | 1 | Keep packet, hand to forwarder |
| pr_reject | input | 1 | Drop packet, hand back to writer |
| fw_ready | output | 1 | Forwarder queue holds a buffer |
| fw_buf | output | 2 | Buffer connected to the forwarder |
| fw_addr | input | ADDR_W | Forwarder read address |
| fw_data | output | DATA_W | Read word, one cycle after address |
| fw_len | output | LEN_W | Length of forwarder's packet |
| fw_done | input | 1 | Forwarder finished sending |

## Verification
The hardest state to reach is the one where the writer queue receives two tokens in the same cycle, which needs one buffer sitting with the processor and another with the forwarder while both finish together; a directed sequence fills two buffers, accepts one, then pulses reject and forwarder done together and walks the writer through the returned order. A second directed step drains the writer queue completely and then drives writes and a done into the empty writer, showing through later buffer selection that nothing moved. A long random phase with a behavioural queue model then covers the mix of simultaneous events and reads across all rotations.

// File: rtl/tribuf_pkg.sv
// Package: shared types and constants for the three-buffer rotation controller.
// Assumes exactly three buffers and three agents.
package tribuf_pkg;
    localparam int NBUF  = 3;
    localparam int TOK_W = 2;
    typedef logic [TOK_W-1:0] tok_t;
    localparam int AG_WR = 0;
    localparam int AG_PR = 1;
    localparam int AG_FW = 2;
endpackage

// File: rtl/tribuf_token_fifo.sv
// Token queue: a small shift-register FIFO holding buffer tokens.
// Supports one pop and up to two ordered pushes (a before b) per cycle.
// Assumes the caller never pushes more tokens than the queue can hold.
module tribuf_token_fifo
    import tribuf_pkg::*;
#(
    parameter int DEPTH    = 3,
    parameter bit RST_FULL = 1'b0,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push_a,
    input  tok_t             tok_a,
    input  logic             push_b,
    input  tok_t             tok_b,
    output tok_t             head,
    output logic             not_empty,
    output logic [CNT_W-1:0] count
);
    tok_t             slot_q [DEPTH];
    tok_t             slot_d [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next-state: pop shifts toward the head, then pushes append in order.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
        cnt_d = cnt_q;
        if (pop && cnt_q != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i+1];
            cnt_d = cnt_d - 1'b1;
        end
        if (push_a) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == cnt_d) slot_d[i] = tok_a;
            cnt_d = cnt_d + 1'b1;
        end
        if (push_b) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == cnt_d) slot_d[i] = tok_b;
            cnt_d = cnt_d + 1'b1;
        end
    end

    // State register; the reset variant is picked by RST_FULL.
    generate
        if (RST_FULL) begin : g_full
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) slot_q[i] <= TOK_W'(i);
                    cnt_q <= CNT_W'(DEPTH);
                end else begin
                    for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
                    cnt_q <= cnt_d;
                end
            end
        end else begin : g_empty
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
                    cnt_q <= '0;
                end else begin
                    for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
                    cnt_q <= cnt_d;
                end
            end
        end
    endgenerate

    assign head      = slot_q[0];
    assign not_empty = (cnt_q != '0);
    assign count     = cnt_q;
endmodule

// File: rtl/tribuf_bank.sv
// Buffer bank: NBUF single-write, single-read RAMs plus a length register each.
// Read port of each RAM is steered to the processor when it owns that buffer,
// otherwise to the forwarder. Read data appears one cycle after the address.
// Assumes the controller only enables writes to a buffer the writer owns.
module tribuf_bank
    import tribuf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int LEN_W  = 7,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  tok_t              wsel,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              pa_vld,
    input  tok_t              pa_sel,
    input  logic [ADDR_W-1:0] pa_addr,
    input  tok_t              pb_sel,
    input  logic [ADDR_W-1:0] pb_addr,
    output logic [DATA_W-1:0] pa_data,
    output logic [LEN_W-1:0]  pa_len,
    output logic [DATA_W-1:0] pb_data,
    output logic [LEN_W-1:0]  pb_len
);
    logic [DATA_W-1:0] rd_q  [NBUF];
    logic [LEN_W-1:0]  len_q [NBUF];
    tok_t              pa_sel_q;
    tok_t              pb_sel_q;

    generate
        for (genvar b = 0; b < NBUF; b++) begin : g_buf
            logic [DATA_W-1:0] mem [DEPTH];
            logic [ADDR_W-1:0] raddr;

            // Read address steering: processor if it owns this buffer.
            always_comb begin
                raddr = (pa_vld && pa_sel == TOK_W'(b)) ? pa_addr : pb_addr;
            end

            // RAM write and registered read.
            always_ff @(posedge clk) begin
                if (we && wsel == TOK_W'(b)) mem[waddr] <= wdata;
                rd_q[b] <= mem[raddr];
            end

            // Length capture at packet completion.
            always_ff @(posedge clk) begin
                if (!rst_n)                          len_q[b] <= '0;
                else if (len_we && wsel == TOK_W'(b)) len_q[b] <= len_in;
            end
        end
    endgenerate

    // Remember which buffer each reader addressed, for the output mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_sel_q <= '0;
            pb_sel_q <= '0;
        end else begin
            pa_sel_q <= pa_sel;
            pb_sel_q <= pb_sel;
        end
    end

    // Output multiplexers for read data and lengths.
    always_comb begin
        pa_data = '0;
        pb_data = '0;
        pa_len  = '0;
        pb_len  = '0;
        for (int b = 0; b < NBUF; b++) begin
            if (pa_sel_q == TOK_W'(b)) pa_data = rd_q[b];
            if (pb_sel_q == TOK_W'(b)) pb_data = rd_q[b];
            if (pa_sel   == TOK_W'(b)) pa_len  = len_q[b];
            if (pb_sel   == TOK_W'(b)) pb_len  = len_q[b];
        end
    end
endmodule

// File: rtl/tribuf_rotator.sv
// Three-buffer token rotation controller (top).
// Writer, processor and forwarder each own a token queue; the head token
// connects the agent to one buffer. Events move head tokens:
//   writer done -> processor, accept -> forwarder,
//   reject -> writer, forwarder done -> writer (reject pushed first).
// Assumes events are single-cycle pulses; events of a not-ready agent are ignored.
module tribuf_rotator
    import tribuf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              wr_ready,
    output logic [1:0]        wr_buf,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_done,
    input  logic [LEN_W-1:0]  wr_len,
    output logic              pr_ready,
    output logic [1:0]        pr_buf,
    input  logic [ADDR_W-1:0] pr_addr,
    output logic [DATA_W-1:0] pr_data,
    output logic [LEN_W-1:0]  pr_len,
    input  logic              pr_accept,
    input  logic              pr_reject,
    output logic              fw_ready,
    output logic [1:0]        fw_buf,
    input  logic [ADDR_W-1:0] fw_addr,
    output logic [DATA_W-1:0] fw_data,
    output logic [LEN_W-1:0]  fw_len,
    input  logic              fw_done
);
    localparam int QDEPTH = NBUF;
    localparam int CNT_W  = $clog2(QDEPTH + 1);

    tok_t             head   [NBUF];
    logic             vld    [NBUF];
    logic [CNT_W-1:0] qcnt   [NBUF];
    logic             pop    [NBUF];
    logic             push_a [NBUF];
    logic             push_b [NBUF];
    tok_t             tok_a  [NBUF];
    tok_t             tok_b  [NBUF];

    logic ev_wdone, ev_acc, ev_rej, ev_fdone;
    logic [CNT_W-1:0] cnt_wr, cnt_pr, cnt_fw;

    // Qualify events with the owning agent's readiness; accept beats reject.
    always_comb begin
        ev_wdone = wr_done   && vld[AG_WR];
        ev_acc   = pr_accept && vld[AG_PR];
        ev_rej   = pr_reject && !pr_accept && vld[AG_PR];
        ev_fdone = fw_done   && vld[AG_FW];
    end

    // Token routing between queues.
    always_comb begin
        pop[AG_WR]    = ev_wdone;
        push_a[AG_WR] = ev_rej;
        tok_a[AG_WR]  = head[AG_PR];
        push_b[AG_WR] = ev_fdone;
        tok_b[AG_WR]  = head[AG_FW];

        pop[AG_PR]    = ev_acc || ev_rej;
        push_a[AG_PR] = ev_wdone;
        tok_a[AG_PR]  = head[AG_WR];
        push_b[AG_PR] = 1'b0;
        tok_b[AG_PR]  = '0;

        pop[AG_FW]    = ev_fdone;
        push_a[AG_FW] = ev_acc;
        tok_a[AG_FW]  = head[AG_PR];
        push_b[AG_FW] = 1'b0;
        tok_b[AG_FW]  = '0;
    end

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_q
            tribuf_token_fifo #(
                .DEPTH    (QDEPTH),
                .RST_FULL (g == AG_WR)
            ) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .pop       (pop[g]),
                .push_a    (push_a[g]),
                .tok_a     (tok_a[g]),
                .push_b    (push_b[g]),
                .tok_b     (tok_b[g]),
                .head      (head[g]),
                .not_empty (vld[g]),
                .count     (qcnt[g])
            );
        end
    endgenerate

    tribuf_bank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && vld[AG_WR]),
        .wsel    (head[AG_WR]),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .len_we  (ev_wdone),
        .len_in  (wr_len),
        .pa_vld  (vld[AG_PR]),
        .pa_sel  (head[AG_PR]),
        .pa_addr (pr_addr),
        .pb_sel  (head[AG_FW]),
        .pb_addr (fw_addr),
        .pa_data (pr_data),
        .pa_len  (pr_len),
        .pb_data (fw_data),
        .pb_len  (fw_len)
    );

    // Status outputs toward the agents.
    always_comb begin
        wr_ready = vld[AG_WR];
        pr_ready = vld[AG_PR];
        fw_ready = vld[AG_FW];
        wr_buf   = head[AG_WR];
        pr_buf   = head[AG_PR];
        fw_buf   = head[AG_FW];
        cnt_wr   = qcnt[AG_WR];
        cnt_pr   = qcnt[AG_PR];
        cnt_fw   = qcnt[AG_FW];
    end
endmodule

// File: rtl/tribuf_rotator_chk.sv
// Checker for tribuf_rotator: token conservation and event hand-offs.
// Bound to every instance of the top; observes ports and queue occupancies.
module tribuf_rotator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ready,
    input logic [1:0] wr_buf,
    input logic       wr_done,
    input logic       pr_ready,
    input logic [1:0] pr_buf,
    input logic       pr_accept,
    input logic       pr_reject,
    input logic       fw_ready,
    input logic [1:0] fw_buf,
    input logic       fw_done,
    input logic [1:0] cnt_wr,
    input logic [1:0] cnt_pr,
    input logic [1:0] cnt_fw
);
    assert_token_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt_wr) + 32'(cnt_pr) + 32'(cnt_fw)) == 3);

    assert_distinct_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !((wr_ready && pr_ready && wr_buf == pr_buf) ||
          (wr_ready && fw_ready && wr_buf == fw_buf) ||
          (pr_ready && fw_ready && pr_buf == fw_buf)));

    assert_wdone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wr_ready && cnt_pr == 2'd0) |=> (pr_ready && pr_buf == $past(wr_buf)));

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_accept && pr_ready && cnt_fw == 2'd0) |=> (fw_ready && fw_buf == $past(pr_buf)));

    assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_reject && !pr_accept && pr_ready) |=> wr_ready);

    assert_fwdone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_done && fw_ready) |=> wr_ready);

    assert_idle_fw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fw_ready && !(pr_accept && pr_ready)) |=> !fw_ready);

    assert_accept_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_accept && pr_reject && pr_ready && !wr_done && !fw_done)
            |=> cnt_wr == $past(cnt_wr));
endmodule

bind tribuf_rotator tribuf_rotator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ready  (wr_ready),
    .wr_buf    (wr_buf),
    .wr_done   (wr_done),
    .pr_ready  (pr_ready),
    .pr_buf    (pr_buf),
    .pr_accept (pr_accept),
    .pr_reject (pr_reject),
    .fw_ready  (fw_ready),
    .fw_buf    (fw_buf),
    .fw_done   (fw_done),
    .cnt_wr    (cnt_wr),
    .cnt_pr    (cnt_pr),
    .cnt_fw    (cnt_fw)
);

// File: tb/tribuf_rotator_tb_top.sv
// Bench: behavioural queue model compared with the design every cycle,
// plus directed steps for reset, hand-offs, ordering and ignored events.
module tribuf_rotator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 6;
    localparam int LW = 7;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_ready, pr_ready, fw_ready;
    logic [1:0]    wr_buf, pr_buf, fw_buf;
    logic          wr_en = 0, wr_done = 0, pr_accept = 0, pr_reject = 0, fw_done = 0;
    logic [AW-1:0] wr_addr = 0, pr_addr = 0, fw_addr = 0;
    logic [DW-1:0] wr_data = 0, pr_data, fw_data;
    logic [LW-1:0] wr_len = 0, pr_len, fw_len;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // Reference model state.
    int            wq[$];
    int            pq[$];
    int            fq[$];
    logic [DW-1:0] mmem [3][1<<AW];
    bit            mset [3][1<<AW];
    logic [LW-1:0] mlen [3];
    bit            pd_ok, fd_ok;
    logic [DW-1:0] pd_exp, fd_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    tribuf_rotator #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_ready(wr_ready), .wr_buf(wr_buf), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_done(wr_done), .wr_len(wr_len),
        .pr_ready(pr_ready), .pr_buf(pr_buf), .pr_addr(pr_addr), .pr_data(pr_data),
        .pr_len(pr_len), .pr_accept(pr_accept), .pr_reject(pr_reject),
        .fw_ready(fw_ready), .fw_buf(fw_buf), .fw_addr(fw_addr), .fw_data(fw_data),
        .fw_len(fw_len), .fw_done(fw_done)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic clear_inputs();
        wr_en = 0; wr_done = 0; pr_accept = 0; pr_reject = 0; fw_done = 0;
    endtask

    task automatic model_reset();
        wq = {0, 1, 2};
        pq = {};
        fq = {};
        pd_ok = 0; fd_ok = 0;
        for (int b = 0; b < 3; b++) begin
            mlen[b] = '0;
            for (int a = 0; a < (1<<AW); a++) mset[b][a] = 0;
        end
    endtask

    // Advance the model by one clock using the currently driven inputs.
    task automatic model_step();
        bit wv, pv, fv, wd, ac, rj, fd;
        int tw, tp, tf;
        wv = wq.size() > 0; pv = pq.size() > 0; fv = fq.size() > 0;
        wd = wr_done && wv;
        ac = pr_accept && pv;
        rj = pr_reject && !pr_accept && pv;
        fd = fw_done && fv;
        tw = wv ? wq[0] : 0; tp = pv ? pq[0] : 0; tf = fv ? fq[0] : 0;
        pd_ok = pv && mset[tp][pr_addr];
        if (pd_ok) pd_exp = mmem[tp][pr_addr];
        fd_ok = fv && mset[tf][fw_addr];
        if (fd_ok) fd_exp = mmem[tf][fw_addr];
        if (wr_en && wv) begin
            mmem[tw][wr_addr] = wr_data;
            mset[tw][wr_addr] = 1;
        end
        if (wd) mlen[tw] = wr_len;
        if (wd) void'(wq.pop_front());
        if (ac || rj) void'(pq.pop_front());
        if (fd) void'(fq.pop_front());
        if (wd) pq.push_back(tw);
        if (ac) fq.push_back(tp);
        if (rj) wq.push_back(tp);   // R7: reject return goes first
        if (fd) wq.push_back(tf);
    endtask

    // Compare all outputs with the model (sampled at the falling edge).
    task automatic compare();
        check("R6", "wr_ready", wr_ready, wq.size() > 0);
        check("R6", "pr_ready", pr_ready, pq.size() > 0);
        check("R6", "fw_ready", fw_ready, fq.size() > 0);
        if (wq.size() > 0) check("R10", "wr_buf", wr_buf, wq[0]);
        if (pq.size() > 0) begin
            check("R10", "pr_buf", pr_buf, pq[0]);
            check("R9", "pr_len", pr_len, mlen[pq[0]]);
        end
        if (fq.size() > 0) begin
            check("R10", "fw_buf", fw_buf, fq[0]);
            check("R9", "fw_len", fw_len, mlen[fq[0]]);
        end
        if (pd_ok) check("R9", "pr_data", pr_data, pd_exp);
        if (fd_ok) check("R9", "fw_data", fw_data, fd_exp);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        clear_inputs();
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        pr_accept = 1; fw_done = 1;      // events while held in reset
        @(negedge clk);
        clear_inputs();
        rst_n = 1;
        // R1: reset state
        check("R1", "wr_ready", wr_ready, 1);
        check("R1", "wr_buf", wr_buf, 0);
        check("R1", "pr_ready", pr_ready, 0);
        check("R1", "fw_ready", fw_ready, 0);

        wr_en = 1; wr_addr = 0; wr_data = 32'hA0A0_0001; tick();
        wr_en = 1; wr_addr = 1; wr_data = 32'hB0B0_0002; tick();
        wr_done = 1; wr_len = 7'd2; tick();
        check("R2", "pr_buf after done", pr_buf, 0);
        check("R2", "wr_buf after done", wr_buf, 1);
        pr_addr = 1; tick();
        check("R9", "pr_data directed", pr_data, 32'hB0B0_0002);
        check("R9", "pr_len directed", pr_len, 2);
        wr_done = 1; wr_len = 7'd3; tick();            // pang to processor
        pr_accept = 1; tick();
        check("R3", "fw_buf after accept", fw_buf, 0);
        check("R3", "pr_buf after accept", pr_buf, 1);
        fw_addr = 0; tick();
        check("R9", "fw_data directed", fw_data, 32'hA0A0_0001);
        pr_reject = 1; fw_done = 1; tick();             // both return to writer
        check("R4", "wr_buf head", wr_buf, 2);
        wr_done = 1; tick();
        check("R7", "rejected buffer next", wr_buf, 1);
        wr_done = 1; tick();
        check("R7", "forwarded buffer last", wr_buf, 0);
        check("R5", "forwarded returned", wr_ready, 1);
        pr_accept = 1; pr_reject = 1; tick();
        check("R8", "fw_buf accept wins", fw_buf, 2);
        check("R8", "pr_buf after accept", pr_buf, 1);
        wr_done = 1; tick();
        check("R6", "writer empty", wr_ready, 0);
        wr_en = 1; wr_done = 1; wr_addr = 3; wr_data = 32'hDEAD; tick();
        check("R6", "writer still empty", wr_ready, 0);
        check("R6", "processor head unchanged", pr_buf, 1);
        fw_done = 1; tick();
        check("R6", "only forwarded token in writer", wr_buf, 2);
        check("R5", "writer ready after return", wr_ready, 1);

        // Random phase.
        for (int n = 0; n < 4000; n++) begin
            wr_en     = $urandom_range(0, 1);
            wr_addr   = AW'($urandom_range(0, 7));
            wr_data   = $urandom;
            wr_done   = ($urandom_range(0, 5) == 0);
            wr_len    = LW'($urandom_range(1, 64));
            pr_addr   = AW'($urandom_range(0, 7));
            pr_accept = ($urandom_range(0, 5) == 0);
            pr_reject = ($urandom_range(0, 5) == 0);
            fw_addr   = AW'($urandom_range(0, 7));
            fw_done   = ($urandom_range(0, 4) == 0);
            tick();
        end
        finish_run();
    end
endmodule